// File: doc/BRIEF.md
# I2C Register Initialization Sequencer

This block is a write-only I2C master that brings up an external device by programming a short, fixed list of its registers. It runs after a one-cycle start strobe. Each register gets its own bus transaction: a START condition, then three bytes (device address, register address, data value), then a STOP condition. The bus then rests idle for a programmable number of SCL periods before the next write begins. The slave's register auto-increment feature is therefore never used, and any single register can be reprogrammed without a burst.

The clock line is derived from the system clock by a quarter-period divider. SDA is open-drain: the block only asserts a drive-low enable, and it reads the resolved line back through an input. In the ninth clock of every byte the master releases SDA. If the line is low at the middle of that high phase, the acknowledge counter advances. A missing acknowledge does not stop the sequence. When the last write has finished, the block raises done, drops busy and leaves both lines released until a new start strobe arrives.

Top module: `i2c_init_seq`

## Requirements
- R1: After reset, SCL is high, SDA is released (drive-low enable 0), busy is 0, done is 0 and the acknowledge count is 0.
- R2: A start strobe while not busy raises busy on the following cycle and begins a transaction with a START condition, in which SDA falls while SCL is high.
- R3: Five transactions are issued in this order, each one carrying three bytes sent MSB first: 0x56, then the register address, then the value. The (address, value) pairs are (0x00,0x02), (0x03,0x00), (0x05,0x09), (0x07,0x07) and (0x09,0x00).
- R4: Outside START and STOP conditions, the master changes SDA only while SCL is low.
- R5: The master releases SDA during the ninth SCL clock of each byte. The acknowledge count rises by exactly one for each byte whose ninth clock finds SDA low at the middle of the SCL high phase.
- R6: A byte that is not acknowledged does not abort the sequence. All five transactions still complete.
- R7: Each transaction ends with a STOP condition, in which SDA rises while SCL is high, after the acknowledge slot of the data byte.
- R8: Between the STOP of one transaction and the START of the next, the bus stays idle (both lines high) for at least IDLE_GAP SCL periods, where one SCL period is 4*CLK_DIV system clocks.
- R9: After the fifth transaction, done is 1 and busy is 0. SCL stays high and SDA stays released until the next start strobe.
- R10: A start strobe while busy is ignored. The sequence and the acknowledge count continue unchanged.
- R11: A start strobe while done clears done and the acknowledge count, then runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that begins the write sequence |
| sda_i | input | 1 | Resolved SDA line level |
| sda_oe_o | output | 1 | SDA drive-low enable (1 pulls the line low) |
| scl_o | output | 1 | Generated SCL level |
| ack_cnt_o | output | ACK_W | Number of acknowledged bytes in the current run |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |

## Verification
The hardest situation to reach from the ports is an irregular pattern of acknowledge and no-acknowledge across the fifteen byte slots, combined with a start strobe that arrives in the middle of a transaction. The stimulus is a bench slave model that decodes SCL and SDA. It decides, by seeded random draws, whether to pull SDA low in each ninth clock, so the acknowledge counter and the decoded byte stream are checked against a freshly counted expectation on every run. Directed runs with every byte acknowledged, with no byte acknowledged, and with a strobe injected while busy cover the extremes.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    localparam int SEQ_ENTRIES = 5;
    localparam int BYTES_PER_TXN = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    // register address / value pair for table slot idx
    function automatic logic [15:0] table_entry(input int idx);
        case (idx)
            0:       table_entry = {8'h00, 8'h02};
            1:       table_entry = {8'h03, 8'h00};
            2:       table_entry = {8'h05, 8'h09};
            3:       table_entry = {8'h07, 8'h07};
            4:       table_entry = {8'h09, 8'h00};
            default: table_entry = {8'h00, 8'h00};
        endcase
    endfunction

    // byte to shift out at position pos of a transaction
    function automatic logic [7:0] pick_byte(input logic [1:0] pos,
                                             input logic [7:0] dev,
                                             input logic [15:0] entry);
        case (pos)
            2'd0:    pick_byte = dev;
            2'd1:    pick_byte = entry[15:8];
            2'd2:    pick_byte = entry[7:0];
            default: pick_byte = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        tick_d = 1'b0;
        if (cnt_q == CW'(DIV - 1)) begin
            cnt_d  = '0;
            tick_d = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] din_i,
    output logic         msb_o
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i)
            sr_d = din_i;
        else if (shift_i)
            sr_d = {sr_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '1;
        else
            sr_q <= sr_d;
    end

    assign msb_o = sr_q[W-1];

endmodule

// File: rtl/i2c_init_seq.sv
module i2c_init_seq
    import i2c_seq_pkg::*;
#(
    parameter int          CLK_DIV  = 4,
    parameter int          IDLE_GAP = 8,
    parameter logic [7:0]  DEV_ADDR = 8'h56,
    parameter int          ACK_W    = $clog2(SEQ_ENTRIES * BYTES_PER_TXN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    output logic             scl_o,
    output logic [ACK_W-1:0] ack_cnt_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int GAP_TICKS = IDLE_GAP * 4;
    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam int RW = $clog2(SEQ_ENTRIES);
    localparam int BIT_SLOTS = 9;

    typedef struct packed {
        seq_state_e       st;
        logic [1:0]       phase;
        logic [3:0]       slot;
        logic [1:0]       bpos;
        logic [RW-1:0]    ridx;
        logic [GW-1:0]    gap;
        logic [ACK_W-1:0] ack;
        logic             scl;
        logic             sda_oe;
        logic             done;
    } seq_regs_t;

    seq_regs_t d, q;
    logic      tick;
    logic      sh_load, sh_shift, sh_msb;
    logic [7:0] sh_din;
    logic [15:0] entry;

    i2c_quarter_tick #(.DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    i2c_byte_shifter #(.W(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .shift_i (sh_shift),
        .din_i   (sh_din),
        .msb_o   (sh_msb)
    );

    assign entry = table_entry(int'(q.ridx));

    always_comb begin
        d        = q;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_din   = pick_byte(2'd0, DEV_ADDR, entry);

        case (q.st)
            ST_IDLE, ST_DONE: begin
                d.sda_oe = 1'b0;
                if (start_i) begin
                    d.st    = ST_START;
                    d.phase = 2'd0;
                    d.ridx  = '0;
                    d.bpos  = 2'd0;
                    d.ack   = '0;
                    d.done  = 1'b0;
                end
            end
            ST_START: if (tick) begin
                d.phase = q.phase + 2'd1;
                if (q.phase == 2'd1)
                    d.sda_oe = 1'b1;          // SDA falls, SCL high
                if (q.phase == 2'd3) begin
                    d.st    = ST_BITS;
                    d.slot  = '0;
                    d.bpos  = 2'd0;
                    sh_load = 1'b1;           // first byte of the write
                end
            end
            ST_BITS: if (tick) begin
                d.phase = q.phase + 2'd1;
                case (q.phase)
                    2'd0: begin               // SCL low: update SDA
                        if (q.slot < 4'(BIT_SLOTS - 1)) begin
                            d.sda_oe = ~sh_msb;
                            sh_shift = 1'b1;
                        end else begin
                            d.sda_oe = 1'b0;  // ninth clock: release
                            d.bpos   = q.bpos + 2'd1;
                            sh_din   = pick_byte(q.bpos + 2'd1, DEV_ADDR, entry);
                            sh_load  = 1'b1;
                        end
                    end
                    2'd2: begin               // middle of SCL high
                        if (q.slot == 4'(BIT_SLOTS - 1) && !sda_i)
                            d.ack = q.ack + 1'b1;
                    end
                    2'd3: begin
                        if (q.slot == 4'(BIT_SLOTS - 1)) begin
                            d.slot = '0;
                            if (q.bpos == 2'(BYTES_PER_TXN))
                                d.st = ST_STOP;
                        end else begin
                            d.slot = q.slot + 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
            ST_STOP: if (tick) begin
                d.phase = q.phase + 2'd1;
                if (q.phase == 2'd0)
                    d.sda_oe = 1'b1;
                if (q.phase == 2'd2)
                    d.sda_oe = 1'b0;          // SDA rises, SCL high
                if (q.phase == 2'd3) begin
                    if (q.ridx == RW'(SEQ_ENTRIES - 1)) begin
                        d.st   = ST_DONE;
                        d.done = 1'b1;
                    end else begin
                        d.st   = ST_GAP;
                        d.gap  = '0;
                        d.ridx = q.ridx + 1'b1;
                    end
                end
            end
            ST_GAP: if (tick) begin
                if (q.gap == GW'(GAP_TICKS - 1)) begin
                    d.st    = ST_START;
                    d.phase = 2'd0;
                    d.bpos  = 2'd0;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        d.scl = (d.st == ST_BITS || d.st == ST_STOP) ? d.phase[1] : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.scl    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.sda_oe;
    assign scl_o     = q.scl;
    assign ack_cnt_o = q.ack;
    assign busy_o    = (q.st != ST_IDLE) && (q.st != ST_DONE);
    assign done_o    = q.done;

    AST_SDA_STABLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BITS && $past(q.st) == ST_BITS && q.scl && $past(q.scl))
        |-> $stable(q.sda_oe)); // R4

    AST_RELEASE_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BITS && q.slot == 4'(BIT_SLOTS - 1) && q.scl) |-> !q.sda_oe); // R5

    AST_ACK_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ack != $past(q.ack)) |-> (q.ack == $past(q.ack) + 1'b1 || q.ack == '0)); // R5

    AST_DONE_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && scl_o && !sda_oe_o)); // R9

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (ack_cnt_o >= $past(ack_cnt_o))); // R10

endmodule

// File: tb/tb_i2c_init_seq.sv
module tb_i2c_init_seq;
    localparam int CLK_T    = 10;
    localparam int CLK_DIV  = 2;
    localparam int IDLE_GAP = 3;
    localparam int ACK_W    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic slave_pull = 1'b0;
    logic sda_oe, scl, busy, done;
    logic [ACK_W-1:0] ack_cnt;
    logic sda_line;

    assign sda_line = ~sda_oe & ~slave_pull;

    i2c_init_seq #(.CLK_DIV(CLK_DIV), .IDLE_GAP(IDLE_GAP), .ACK_W(ACK_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .scl_o(scl), .ack_cnt_o(ack_cnt),
        .busy_o(busy), .done_o(done)
    );

    always #(CLK_T/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int m_checks = 0, m_fail = 0;
    int ack_mode = 0;            // 0 random, 1 always, 2 never
    int trans_total = 0, acks_given = 0, starts_seen = 0;
    bit finished = 0;

    function automatic logic [7:0] exp_byte(input int t, input int b);
        logic [7:0] a, v;
        case (t)
            0: begin a = 8'h00; v = 8'h02; end
            1: begin a = 8'h03; v = 8'h00; end
            2: begin a = 8'h05; v = 8'h09; end
            3: begin a = 8'h07; v = 8'h07; end
            default: begin a = 8'h09; v = 8'h00; end
        endcase
        return (b == 0) ? 8'h56 : (b == 1) ? a : v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus monitor and slave model
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int bitcnt = 0, bytecnt = 0, cyc = 0, stop_cyc = 0;
    bit in_txn = 0, gap_valid = 0;
    logic [7:0] cur = 8'h0;
    logic [7:0] got [3];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (scl && prev_scl && prev_sda && !sda_line) begin
                m_checks++;
                if (in_txn) begin m_fail++; $display("FAIL R4 START inside transaction actual=1 expected=0"); end
                if (gap_valid) begin
                    m_checks++;
                    if (cyc - stop_cyc < 4*IDLE_GAP*CLK_DIV) begin
                        m_fail++;
                        $display("FAIL R8 idle gap actual=%0d expected>=%0d", cyc - stop_cyc, 4*IDLE_GAP*CLK_DIV);
                    end
                end
                in_txn = 1; bitcnt = 0; bytecnt = 0; starts_seen++;
            end else if (scl && prev_scl && !prev_sda && sda_line) begin
                m_checks++;
                if (bytecnt != 3) begin m_fail++; $display("FAIL R7 STOP after bytes actual=%0d expected=3", bytecnt); end
                for (int b = 0; b < 3; b++) begin
                    m_checks++;
                    if (got[b] !== exp_byte(trans_total % 5, b)) begin
                        m_fail++;
                        $display("FAIL R3 txn %0d byte %0d actual=%0h expected=%0h",
                                 trans_total % 5, b, got[b], exp_byte(trans_total % 5, b));
                    end
                end
                trans_total++;
                in_txn = 0;
                gap_valid = (trans_total % 5) != 0;
                stop_cyc = cyc;
            end else if (scl && !prev_scl) begin
                if (bitcnt < 8) begin
                    cur = {cur[6:0], sda_line};
                    bitcnt++;
                end else if (bitcnt == 8) begin
                    if (bytecnt < 3) got[bytecnt] = cur;
                    bytecnt++;
                    bitcnt = 0;
                end
            end else if (!scl && prev_scl) begin
                if (in_txn && bitcnt == 8) begin
                    slave_pull = (ack_mode == 1) ? 1'b1 : (ack_mode == 2) ? 1'b0 : 1'($urandom_range(0, 1));
                    if (slave_pull) acks_given++;
                end else begin
                    slave_pull = 1'b0;
                end
            end
        end
        prev_scl = scl;
        prev_sda = sda_line;
    end

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic run_seq(input int mode, input bit poke_busy, input string tag);
        int t0, a0, s0;
        ack_mode = mode;
        t0 = trans_total; a0 = acks_given; s0 = starts_seen;
        pulse_start();
        check(busy === 1'b1 && done === 1'b0, "R2 busy after start", busy, 1);
        if (poke_busy) begin
            repeat (300) @(negedge clk);
            pulse_start();          // R10: ignored while busy
            check(busy === 1'b1, "R10 still busy after strobe", busy, 1);
        end
        for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
        check(done === 1'b1 && busy === 1'b0, {"R9 done/busy ", tag}, {done, busy}, 2);
        check(trans_total - t0 == 5, {"R6 transactions completed ", tag}, trans_total - t0, 5);
        check(starts_seen - s0 == 5, {"R2 START count ", tag}, starts_seen - s0, 5);
        check(int'(ack_cnt) == acks_given - a0, {"R5 ack count ", tag}, ack_cnt, acks_given - a0);
        repeat (40) @(negedge clk);
        check(scl === 1'b1 && sda_oe === 1'b0 && done === 1'b1, {"R9 lines released ", tag},
              {scl, sda_oe}, 2);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(scl === 1'b1 && sda_oe === 1'b0 && busy === 1'b0 && done === 1'b0 && ack_cnt == 0,
              "R1 reset state", {scl, sda_oe, busy, done}, 8);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(busy === 1'b0 && ack_cnt == 0, "R1 idle after reset", busy, 0);

        run_seq(1, 1'b0, "all ack");
        check(ack_cnt == 15, "R5 every byte acked", ack_cnt, 15);
        run_seq(2, 1'b0, "no ack");   // R11 restart from done clears count
        check(ack_cnt == 0, "R11 count cleared, R6 no ack", ack_cnt, 0);
        run_seq(0, 1'b1, "random + busy strobe");
        for (int r = 0; r < 3; r++) run_seq(0, 1'b0, "random");

        finished = 1;
        $display("%0d/%0d checks passed", (n_checks + m_checks) - (n_fail + m_fail), n_checks + m_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", (n_checks + m_checks) - (n_fail + m_fail), n_checks + m_checks);
            $finish;
        end
    end
endmodule